// File: doc/BRIEF.md
# Multi-channel inter-processor mailbox

This block sits on a simple register bus and lets a local processor pass fixed-length messages of eight 32-bit words to a remote processor over a set of numbered channels. Every channel owns a 64-byte register window with a source (owner) mask, a destination vector mask, a destination-clear port, a destination-status view, a mode/status word, an interrupt mask, an interrupt-clear port, a send trigger and eight message words. One global lock word gates the configuration writes: software must write a key before it can claim or drive a channel.

A channel starts idle. A one-hot owner mask written while idle claims it and makes it ready. Software writes the message, chooses destination vectors and writes its own bit to the send trigger. The channel then becomes busy and raises the unmasked destination interrupt lines. The remote side answers by pulsing that channel's acknowledge input. This drops the lines. In automatic-acknowledge mode the channel then holds an acknowledged status until software clears it through the interrupt-clear port. In manual mode it returns to ready straight away.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every channel is idle (mode word reads 0x10, owner mask 0), the lock word reads 1 and every interrupt output is low.
- R2: Writing 0x1ACCE551 to byte address 0xA00 unlocks, and the word then reads 0. Writing any other value there locks again, and the word then reads 1.
- R3: While locked, writes to the owner (offset 0x00), destination (0x04), mode (0x10) and send (0x1C) registers have no effect.
- R4: A write of a one-hot value to the owner register of an idle channel claims it. The owner register reads back that value and the mode word reads 0x20 (ready) plus bit 0. A write that is not one-hot, or any owner write to a channel that is not idle, is ignored.
- R5: A send write holding the owner's bit, made to a ready channel, makes it busy. From the next cycle irq_o carries the channel's destination mask with the interrupt-mask bits removed, and the mode word shows none of bits 4, 5, 7. A send write without the owner's bit is ignored.
- R6: While a channel is busy, writes to its message words and to its send register are ignored.
- R7: With mode bit 0 set, an acknowledge pulse on a busy channel drops its interrupt lines and sets the acknowledged status (mode reads 0x81). An interrupt-clear write (offset 0x18) holding the owner's bit returns it to ready (0x21). One without that bit is ignored.
- R8: With mode bit 0 clear, an acknowledge pulse on a busy channel drops its interrupt lines and returns it directly to ready (mode reads 0x20).
- R9: A write to destination clear (0x08) clears those bits of the destination mask. Destination status (0x0C) reads the destination mask AND NOT the interrupt mask (0x14). Neither the interrupt mask nor destination clear is gated by the lock.
- R10: Message word k is stored at offset 0x20+4k, for k from 0 to 7, and reads back what was written.
- R11: Channel n occupies byte addresses 0x40·n to 0x40·n+0x3F, and channels hold their state independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 12 | Byte address; writes need bits 1:0 at zero |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| remote_ack_i | input | NUM_CH | Per-channel acknowledge pulse from the remote side |
| irq_o | output | NUM_VEC | Level destination interrupt vectors |

## Verification
If the channel state is wrong, the mode word read in the cycle after the offending write shows the wrong status bits. A busy channel that is not tracked correctly also leaves irq_o stuck high, or never raises it, one cycle after a send or an acknowledge. A wrong lock state shows up when a configuration register reads back unchanged, or changed, right after a write made while locked. Bad window decoding shows up when a write to one channel's register changes what another channel's register reads back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WIN_BYTES = 64;
  localparam int unsigned WIN_WORDS = WIN_BYTES / 4;
  localparam int unsigned MSG_WORDS = WIN_WORDS - 8;
  localparam int unsigned MSG_IW    = $clog2(MSG_WORDS);
  localparam int unsigned OFF_W     = $clog2(WIN_WORDS);

  localparam logic [11:0] LOCK_ADDR = 12'hA00;
  localparam logic [31:0] LOCK_KEY  = 32'h1ACC_E551;

  // word offsets inside a channel window
  localparam logic [OFF_W-1:0] OFF_SRC   = 4'd0;
  localparam logic [OFF_W-1:0] OFF_DST   = 4'd1;
  localparam logic [OFF_W-1:0] OFF_DCLR  = 4'd2;
  localparam logic [OFF_W-1:0] OFF_DSTAT = 4'd3;
  localparam logic [OFF_W-1:0] OFF_MODE  = 4'd4;
  localparam logic [OFF_W-1:0] OFF_IMASK = 4'd5;
  localparam logic [OFF_W-1:0] OFF_ICLR  = 4'd6;
  localparam logic [OFF_W-1:0] OFF_SEND  = 4'd7;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READY = 2'd1,
    CH_BUSY  = 2'd2,
    CH_ACKED = 2'd3
  } ch_state_e;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock
  import mbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           locked_q <= 1'b1;
    else if (wr_i && addr_i == LOCK_ADDR)  locked_q <= (wdata_i != LOCK_KEY);
  end

  assign locked_o = locked_q;

  // R2
  key_unlocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == LOCK_ADDR && wdata_i == LOCK_KEY) |=> !locked_o);
  // R2
  bad_key_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == LOCK_ADDR && wdata_i != LOCK_KEY) |=> locked_o);
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               unlocked_i,
  input  logic               wr_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [31:0]        wdata_i,
  input  logic               ack_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_VEC-1:0] irq_o
);
  ch_state_e                          state_q;
  logic [NUM_VEC-1:0]                 src_q, dst_q, imask_q;
  logic                               auto_q;
  logic [MSG_WORDS-1:0][WORD_W-1:0]   data_q;

  logic [NUM_VEC-1:0] wvec;
  logic               own_bit;
  assign wvec    = wdata_i[NUM_VEC-1:0];
  assign own_bit = |(wvec & src_q);

  logic wr_src, wr_dst, wr_dclr, wr_mode, wr_imask, wr_iclr, wr_send, wr_data;
  assign wr_src   = wr_i && off_i == OFF_SRC   && unlocked_i;
  assign wr_dst   = wr_i && off_i == OFF_DST   && unlocked_i;
  assign wr_dclr  = wr_i && off_i == OFF_DCLR;
  assign wr_mode  = wr_i && off_i == OFF_MODE  && unlocked_i;
  assign wr_imask = wr_i && off_i == OFF_IMASK;
  assign wr_iclr  = wr_i && off_i == OFF_ICLR;
  assign wr_send  = wr_i && off_i == OFF_SEND  && unlocked_i;
  assign wr_data  = wr_i && off_i[OFF_W-1] && state_q != CH_BUSY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
      src_q   <= '0;
    end else begin
      unique case (state_q)
        CH_IDLE:  if (wr_src && $onehot(wvec)) begin
                    src_q   <= wvec;
                    state_q <= CH_READY;
                  end
        CH_READY: if (wr_send && own_bit) state_q <= CH_BUSY;
        CH_BUSY:  if (ack_i) state_q <= auto_q ? CH_ACKED : CH_READY;
        CH_ACKED: if (wr_iclr && own_bit) state_q <= CH_READY;
        default:  state_q <= CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      imask_q <= '0;
      auto_q  <= 1'b0;
    end else begin
      if (wr_dst)        dst_q <= wvec;
      else if (wr_dclr)  dst_q <= dst_q & ~wvec;
      if (wr_imask)      imask_q <= wvec;
      if (wr_mode)       auto_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_data) data_q[off_i[MSG_IW-1:0]] <= wdata_i;
  end

  logic [7:0] mode_rd;
  assign mode_rd = {state_q == CH_ACKED, 1'b0, state_q == CH_READY,
                    state_q == CH_IDLE, 3'b000, auto_q};

  always_comb begin
    rdata_o = '0;
    if (off_i[OFF_W-1]) rdata_o = data_q[off_i[MSG_IW-1:0]];
    else begin
      unique case (off_i)
        OFF_SRC:   rdata_o[NUM_VEC-1:0] = src_q;
        OFF_DST:   rdata_o[NUM_VEC-1:0] = dst_q;
        OFF_DSTAT: rdata_o[NUM_VEC-1:0] = dst_q & ~imask_q;
        OFF_MODE:  rdata_o[7:0]         = mode_rd;
        OFF_IMASK: rdata_o[NUM_VEC-1:0] = imask_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (state_q == CH_BUSY) ? (dst_q & ~imask_q) : '0;

  // R4
  owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != CH_IDLE) |-> $onehot(src_q));
  // R4
  owner_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != CH_IDLE) |=> $stable(src_q));
  // R6
  busy_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_BUSY) |=> $stable(data_q));
  // R3
  locked_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_i && state_q == CH_READY && !wr_iclr) |=> state_q == CH_READY);
  // R7
  auto_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_BUSY && ack_i && auto_q) |=> (state_q == CH_ACKED && irq_o == '0));
  // R8
  manual_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_BUSY && ack_i && !auto_q) |=> (state_q == CH_READY && irq_o == '0));
endmodule

// File: rtl/mbox_irq_merge.sv
module mbox_irq_merge #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic [NUM_CH-1:0][NUM_VEC-1:0] req_i,
  output logic [NUM_VEC-1:0]             irq_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [NUM_CH-1:0] col;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign col[c] = req_i[c][v];
    end
    assign irq_o[v] = |col;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_CH-1:0]  remote_ack_i,
  output logic [NUM_VEC-1:0] irq_o
);
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned WIN_SH = $clog2(WIN_BYTES);

  logic                 wr;
  logic                 locked;
  logic                 in_range;
  logic [CH_W-1:0]      ch_idx;
  logic [OFF_W-1:0]     off;
  logic [11-WIN_SH:0]   win;

  assign wr       = bus_en_i && bus_we_i && bus_addr_i[1:0] == 2'b00;
  assign win      = bus_addr_i[11:WIN_SH];
  assign in_range = 32'(win) < NUM_CH;
  assign ch_idx   = bus_addr_i[WIN_SH +: CH_W];
  assign off      = bus_addr_i[WIN_SH-1:2];

  mbox_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .locked_o(locked)
  );

  logic [NUM_CH-1:0][31:0]      ch_rdata;
  logic [NUM_CH-1:0][NUM_VEC-1:0] ch_irq;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbox_channel #(.NUM_VEC(NUM_VEC)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .unlocked_i(!locked),
      .wr_i      (wr && in_range && ch_idx == CH_W'(c)),
      .off_i     (off),
      .wdata_i   (bus_wdata_i),
      .ack_i     (remote_ack_i[c]),
      .rdata_o   (ch_rdata[c]),
      .irq_o     (ch_irq[c])
    );
  end

  mbox_irq_merge #(.NUM_CH(NUM_CH), .NUM_VEC(NUM_VEC)) u_irq (
    .req_i(ch_irq),
    .irq_o(irq_o)
  );

  always_comb begin
    if (bus_addr_i == LOCK_ADDR) bus_rdata_o = {31'd0, locked};
    else if (in_range)           bus_rdata_o = ch_rdata[ch_idx];
    else                         bus_rdata_o = '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (irq_o == '0 && locked));
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int NUM_CH  = 32;
  localparam int NUM_VEC = 32;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [NUM_CH-1:0]  remote_ack = '0;
  logic [NUM_VEC-1:0] irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipc_mailbox #(.NUM_CH(NUM_CH), .NUM_VEC(NUM_VEC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .remote_ack_i(remote_ack), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic ack_pulse(int ch);
    @(negedge clk);
    remote_ack[ch] = 1'b1;
    @(negedge clk);
    remote_ack[ch] = 1'b0;
  endtask

  // {write, addr, data/expected, requirement}; channel 2 base 0x080, channel 3 base 0x0C0
  localparam int NV = 31;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 12'hA00, 32'h0000_0001, 4'd1},   // R1 locked after reset
    {1'b0, 12'h090, 32'h0000_0010, 4'd1},   // R1 idle
    {1'b1, 12'h080, 32'h0000_0004, 4'd3},   // R3 claim while locked
    {1'b0, 12'h080, 32'h0000_0000, 4'd3},
    {1'b1, 12'hA00, 32'h1ACC_E551, 4'd2},   // R2 unlock
    {1'b0, 12'hA00, 32'h0000_0000, 4'd2},
    {1'b1, 12'h080, 32'h0000_0006, 4'd4},   // R4 not one-hot
    {1'b0, 12'h080, 32'h0000_0000, 4'd4},
    {1'b1, 12'h080, 32'h0000_0004, 4'd4},   // R4 claim
    {1'b0, 12'h080, 32'h0000_0004, 4'd4},
    {1'b0, 12'h090, 32'h0000_0020, 4'd4},
    {1'b1, 12'h084, 32'h0000_0030, 4'd9},   // R9
    {1'b1, 12'h094, 32'h0000_0010, 4'd9},
    {1'b0, 12'h08C, 32'h0000_0020, 4'd9},
    {1'b1, 12'h088, 32'h0000_0020, 4'd9},
    {1'b0, 12'h084, 32'h0000_0010, 4'd9},
    {1'b0, 12'h08C, 32'h0000_0000, 4'd9},
    {1'b1, 12'h084, 32'h0000_0030, 4'd9},
    {1'b1, 12'h0A0, 32'hDEAD_BEEF, 4'd10},  // R10
    {1'b1, 12'h0BC, 32'h1234_5678, 4'd10},
    {1'b0, 12'h0A0, 32'hDEAD_BEEF, 4'd10},
    {1'b0, 12'h0BC, 32'h1234_5678, 4'd10},
    {1'b1, 12'h0C0, 32'h0000_0008, 4'd11},  // R11
    {1'b0, 12'h0C0, 32'h0000_0008, 4'd11},
    {1'b0, 12'h080, 32'h0000_0004, 4'd11},
    {1'b1, 12'hA00, 32'h0000_0000, 4'd2},   // R2 relock
    {1'b0, 12'hA00, 32'h0000_0001, 4'd2},
    {1'b1, 12'h084, 32'h0000_FFFF, 4'd3},   // R3 dst locked
    {1'b0, 12'h084, 32'h0000_0030, 4'd3},
    {1'b1, 12'h090, 32'h0000_0001, 4'd3},   // R3 mode locked
    {1'b0, 12'h090, 32'h0000_0020, 4'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", irq, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][47:36], VEC[i][35:4]);
      else rd_chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][47:36], VEC[i][35:4]);
    end

    wr(12'hA00, 32'h1ACC_E551);
    wr(12'h090, 32'h1);
    rd_chk("R4 auto ready", 12'h090, 32'h21);
    wr(12'h09C, 32'h1);
    rd_chk("R5 foreign send ignored", 12'h090, 32'h21);
    check("R5 foreign send irq", irq, 32'h0);
    wr(12'hA00, 32'h0);
    wr(12'h09C, 32'h4);
    check("R3 send locked irq", irq, 32'h0);
    wr(12'hA00, 32'h1ACC_E551);
    wr(12'h09C, 32'h4);
    check("R5 irq", irq, 32'h20);
    rd_chk("R5 busy mode", 12'h090, 32'h01);
    wr(12'h0A0, 32'h1111);
    rd_chk("R6 data held", 12'h0A0, 32'hDEAD_BEEF);
    wr(12'h09C, 32'h4);
    rd_chk("R6 send ignored", 12'h090, 32'h01);
    wr(12'h080, 32'h1);
    rd_chk("R4 reclaim ignored", 12'h080, 32'h4);
    ack_pulse(2);
    check("R7 irq drop", irq, 32'h0);
    rd_chk("R7 acked", 12'h090, 32'h81);
    wr(12'h098, 32'h1);
    rd_chk("R7 wrong clear", 12'h090, 32'h81);
    wr(12'h098, 32'h4);
    rd_chk("R7 cleared", 12'h090, 32'h21);

    wr(12'h0D0, 32'h0);
    wr(12'h0C4, 32'h1);
    wr(12'h0DC, 32'h8);
    check("R8 irq", irq, 32'h1);
    ack_pulse(3);
    check("R8 irq drop", irq, 32'h0);
    rd_chk("R8 ready", 12'h0D0, 32'h20);
    rd_chk("R11 ch2 untouched", 12'h090, 32'h21);

    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    rd_chk("R1 lock after reset", 12'hA00, 32'h1);
    rd_chk("R1 src after reset", 12'h080, 32'h0);
    rd_chk("R1 mode after reset", 12'h0D0, 32'h10);
    check("R1 irq after reset", irq, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule